// File: doc/BRIEF.md
# Video Pixel Output Port Formatter

This block sits at the end of a video decoder pipeline. Each clock it takes one decoded 4:2:2 sample set: luma, both chroma components and an RGB triple, along with the line timing flags (blank, horizontal sync, vertical sync, field, VBI-valid). It drives a 16-bit pixel bus in one of four formats. The formats are byte-serial YCbCr on the upper lane, 16-bit YCbCr, 15-bit RGB and 16-bit RGB. Every output, the timing flags included, is registered, so each one changes only after the rising clock edge, one cycle after the inputs were sampled.

A small line-state machine follows whether the previous cycle was plain blanking, VBI data inside blanking, or active video. It has three states:
- **ST_BLANK**: blank high, VBI-valid low.
- **ST_VBI**: blank high, VBI-valid high.
- **ST_ACTIVE**: blank low.

Each cycle the next state follows from the current flags. The transitions are:
- **go_active**: blank low.
- **go_vbi**: blank high with VBI-valid high.
- **go_blank**: blank high with VBI-valid low.

Taking go_active out of ST_BLANK or ST_VBI is a *line restart*. It forces the 2-bit sample phase to zero, so every line begins on a Cb sample.

While plain blanking is in force, the data is replaced by fixed codes that depend on the format. The data-valid strobe has three behaviours, chosen by a latch-mode bit and a duty-cycle bit, and a polarity input inverts it at the output register.

Top module: `pof_out_fmt`

## Requirements
- R1: `blank_o`, `hsync_o`, `vsync_o`, `field_o` and `vbi_valid_o` equal the matching inputs sampled at the previous rising edge. After reset every output is 0.
- R2: In format 0 (byte-serial YCbCr), the upper lane carries Cb, Y, Cr, Y for sample phases 0 to 3, and the lower lane is 0.
- R3: A line restart (blank falling) sets the phase to 0. The first active output of a line is therefore Cb: on the upper lane in format 0, on the lower lane in format 1.
- R4: In format 1 (16-bit YCbCr), `pix_o[15:8]` is Y. `pix_o[7:0]` is Cb on even phases and Cr on odd phases, and the phase advances by one each clock.
- R5: In format 2 (15-bit RGB), `pix_o` is {0, R[7:3], G[7:3], B[7:3]}.
- R6: In format 3 (16-bit RGB), `pix_o` is {R[7:3], G[7:2], B[7:3]}.
- R7: With blank high and VBI-valid low, the YCbCr formats output the blanking codes: Y = 0x10, Cb/Cr = 0x80. Format 1 gives 0x1080. Format 0 alternates 0x80 and 0x10 on the upper lane.
- R8: With blank high and VBI-valid low, both RGB formats output 0. With blank and VBI-valid both high, the data is formatted normally.
- R9: The format input is loaded only on cycles with blank high. A change during active video takes effect only after the next blanking.
- R10: With latch-mode 0 and duty-cycle 0, the logical strobe is high exactly on cycles with blank low or VBI-valid high.
- R11: With latch-mode 0, duty-cycle 1 and format 0, the logical strobe is high only on even phases of active data. The output reads 1, 0, 1, 0 from line start.
- R12: With latch-mode 1, the logical strobe is held high through active video and toggles every clock during blanking.
- R13: With `dv_pol_i` = 1, `dvalid_o` is the inverse of the logical strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Format: 0 byte YCbCr, 1 16-bit YCbCr, 2 RGB 15, 3 RGB 16 |
| dv_latch_i | input | 1 | Strobe latch-mode select |
| dv_duty_i | input | 1 | Strobe duty-cycle select |
| dv_pol_i | input | 1 | 1 inverts the data-valid output |
| y_i | input | 8 | Luma sample |
| cb_i | input | 8 | Blue-difference sample |
| cr_i | input | 8 | Red-difference sample |
| r_i | input | 8 | Red component |
| g_i | input | 8 | Green component |
| b_i | input | 8 | Blue component |
| blank_i | input | 1 | Blanking flag |
| hsync_i | input | 1 | Horizontal sync |
| vsync_i | input | 1 | Vertical sync |
| field_i | input | 1 | Field flag |
| vbi_valid_i | input | 1 | VBI data valid during blanking |
| pix_o | output | 16 | Pixel output bus |
| blank_o | output | 1 | Registered blank |
| hsync_o | output | 1 | Registered horizontal sync |
| vsync_o | output | 1 | Registered vertical sync |
| dvalid_o | output | 1 | Data-valid strobe |
| vbi_valid_o | output | 1 | Registered VBI-valid |
| field_o | output | 1 | Registered field |

## Verification
The bench drives lines whose lengths are not multiples of four. A design that let the phase run across blanking would then start the next line on Y or Cr, not Cb. It changes the format input in the middle of a line: a formatter that sampled the format at any time would switch the packing mid-line. It runs VBI data inside blanking, where a design that keyed the forced codes on blank alone would output zeros or blanking codes. It also walks the strobe through duty-cycle, latch and inverted-polarity settings, where an error shows as a strobe that is steady when it should toggle or the wrong way up.

// File: rtl/pof_pkg.sv
package pof_pkg;
    typedef enum logic [1:0] {
        MD_YCC8  = 2'd0,
        MD_YCC16 = 2'd1,
        MD_RGB15 = 2'd2,
        MD_RGB16 = 2'd3
    } fmt_mode_e;

    typedef enum logic [1:0] {
        ST_BLANK  = 2'd0,
        ST_VBI    = 2'd1,
        ST_ACTIVE = 2'd2
    } line_st_e;
endpackage

// File: rtl/pof_seq.sv
module pof_seq
    import pof_pkg::*;
#(
    parameter int PH_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            blank_i,
    input  logic            vbi_i,
    input  logic [1:0]      mode_i,
    output logic [PH_W-1:0] phase_o,
    output fmt_mode_e       mode_o,
    output line_st_e        state_o
);
    line_st_e        state_q, state_d;
    logic [PH_W-1:0] phase_q;
    fmt_mode_e       mode_q;
    logic            restart;

    // next state and line restart decode
    always_comb begin
        restart = 1'b0;
        unique case (state_q)
            ST_BLANK:  restart = !blank_i;
            ST_VBI:    restart = !blank_i;
            ST_ACTIVE: restart = 1'b0;
            default:   restart = !blank_i;
        endcase
        if (!blank_i)
            state_d = ST_ACTIVE;
        else if (vbi_i)
            state_d = ST_VBI;
        else
            state_d = ST_BLANK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_BLANK;
        end else begin
            state_q <= state_d;
        end
    end

    assign phase_o = restart ? '0 : phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
            mode_q  <= MD_YCC8;
        end else begin
            phase_q <= phase_o + PH_W'(1);
            if (blank_i)
                mode_q <= fmt_mode_e'(mode_i);
        end
    end

    assign mode_o  = mode_q;
    assign state_o = state_q;
endmodule

// File: rtl/pof_pack.sv
module pof_pack
    import pof_pkg::*;
#(
    parameter int          DW    = 8,
    parameter int          BW    = 2 * DW,
    parameter logic [DW-1:0] Y_BLK = 8'h10,
    parameter logic [DW-1:0] C_BLK = 8'h80
) (
    input  fmt_mode_e     mode_i,
    input  logic [1:0]    phase_i,
    input  logic          force_i,
    input  logic [DW-1:0] y_i,
    input  logic [DW-1:0] cb_i,
    input  logic [DW-1:0] cr_i,
    input  logic [DW-1:0] r_i,
    input  logic [DW-1:0] g_i,
    input  logic [DW-1:0] b_i,
    output logic [BW-1:0] bus_o
);
    logic [DW-1:0] byte_ser;
    logic [DW-1:0] blk_ser;
    logic [DW-1:0] chroma;
    logic [15:0]   rgb15;
    logic [15:0]   rgb16;

    always_comb begin
        chroma   = phase_i[0] ? cr_i : cb_i;
        byte_ser = phase_i[0] ? y_i : (phase_i[1] ? cr_i : cb_i);
        blk_ser  = phase_i[0] ? Y_BLK : C_BLK;
        rgb15    = {1'b0, r_i[DW-1 -: 5], g_i[DW-1 -: 5], b_i[DW-1 -: 5]};
        rgb16    = {r_i[DW-1 -: 5], g_i[DW-1 -: 6], b_i[DW-1 -: 5]};
        bus_o    = '0;
        unique case (mode_i)
            MD_YCC8:  bus_o = {(force_i ? blk_ser : byte_ser), {DW{1'b0}}};
            MD_YCC16: bus_o = force_i ? {Y_BLK, C_BLK} : {y_i, chroma};
            MD_RGB15: bus_o = force_i ? '0 : BW'(rgb15);
            MD_RGB16: bus_o = force_i ? '0 : BW'(rgb16);
            default:  bus_o = '0;
        endcase
    end
endmodule

// File: rtl/pof_dv.sv
module pof_dv (
    input  logic clk,
    input  logic rst_n,
    input  logic blank_i,
    input  logic vbi_i,
    input  logic latch_i,
    input  logic duty_i,
    input  logic ycc8_i,
    input  logic phase0_i,
    output logic dv_o
);
    logic tog_q;
    logic live;

    assign live = !blank_i || vbi_i;

    always_comb begin
        if (latch_i)
            dv_o = blank_i ? tog_q : 1'b1;
        else if (duty_i && ycc8_i)
            dv_o = live && !phase0_i;
        else
            dv_o = live;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            tog_q <= 1'b0;
        else
            tog_q <= blank_i ? ~tog_q : 1'b0;
    end
endmodule

// File: rtl/pof_out_fmt.sv
module pof_out_fmt
    import pof_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  mode_i,
    input  logic        dv_latch_i,
    input  logic        dv_duty_i,
    input  logic        dv_pol_i,
    input  logic [7:0]  y_i,
    input  logic [7:0]  cb_i,
    input  logic [7:0]  cr_i,
    input  logic [7:0]  r_i,
    input  logic [7:0]  g_i,
    input  logic [7:0]  b_i,
    input  logic        blank_i,
    input  logic        hsync_i,
    input  logic        vsync_i,
    input  logic        field_i,
    input  logic        vbi_valid_i,
    output logic [15:0] pix_o,
    output logic        blank_o,
    output logic        hsync_o,
    output logic        vsync_o,
    output logic        dvalid_o,
    output logic        vbi_valid_o,
    output logic        field_o
);
    localparam int DW = 8;
    localparam int BW = 2 * DW;

    logic [1:0]    phase;
    fmt_mode_e     mode_eff;
    line_st_e      line_st;
    logic          force_blk;
    logic [BW-1:0] bus;
    logic          dv_raw;

    assign force_blk = blank_i && !vbi_valid_i;

    pof_seq #(.PH_W(2)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .blank_i (blank_i),
        .vbi_i   (vbi_valid_i),
        .mode_i  (mode_i),
        .phase_o (phase),
        .mode_o  (mode_eff),
        .state_o (line_st)
    );

    pof_pack #(.DW(DW), .BW(BW)) u_pack (
        .mode_i  (mode_eff),
        .phase_i (phase),
        .force_i (force_blk),
        .y_i     (y_i),
        .cb_i    (cb_i),
        .cr_i    (cr_i),
        .r_i     (r_i),
        .g_i     (g_i),
        .b_i     (b_i),
        .bus_o   (bus)
    );

    pof_dv u_dv (
        .clk      (clk),
        .rst_n    (rst_n),
        .blank_i  (blank_i),
        .vbi_i    (vbi_valid_i),
        .latch_i  (dv_latch_i),
        .duty_i   (dv_duty_i),
        .ycc8_i   (mode_eff == MD_YCC8),
        .phase0_i (phase[0]),
        .dv_o     (dv_raw)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pix_o       <= '0;
            blank_o     <= 1'b0;
            hsync_o     <= 1'b0;
            vsync_o     <= 1'b0;
            dvalid_o    <= 1'b0;
            vbi_valid_o <= 1'b0;
            field_o     <= 1'b0;
        end else begin
            pix_o       <= bus;
            blank_o     <= blank_i;
            hsync_o     <= hsync_i;
            vsync_o     <= vsync_i;
            dvalid_o    <= dv_raw ^ dv_pol_i;
            vbi_valid_o <= vbi_valid_i;
            field_o     <= field_i;
        end
    end
endmodule

// File: rtl/pof_chk.sv
module pof_chk
    import pof_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input fmt_mode_e   mode_eff,
    input logic        dv_latch_i,
    input logic        dv_pol_i,
    input logic [7:0]  cb_i,
    input logic        blank_i,
    input logic        hsync_i,
    input logic        vsync_i,
    input logic        field_i,
    input logic        vbi_valid_i,
    input logic [15:0] pix_o,
    input logic        blank_o,
    input logic        hsync_o,
    input logic        vsync_o,
    input logic        dvalid_o,
    input logic        field_o
);
    assert_flag_delay_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (hsync_o == $past(hsync_i) && vsync_o == $past(vsync_i)
                   && field_o == $past(field_i) && blank_o == $past(blank_i)));

    assert_low_lane_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_eff == MD_YCC8) |=> (pix_o[7:0] == 8'h00));

    assert_line_starts_cb_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_eff == MD_YCC8 && !blank_i && $past(blank_i)) |=> (pix_o[15:8] == $past(cb_i)));

    assert_ycc16_blank_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_eff == MD_YCC16 && blank_i && !vbi_valid_i) |=> (pix_o == 16'h1080));

    assert_rgb_blank_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_eff == MD_RGB15 || mode_eff == MD_RGB16) && blank_i && !vbi_valid_i)
        |=> (pix_o == 16'h0000));

    assert_latch_steady_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (dv_latch_i && !blank_i) |=> (dvalid_o == !$past(dv_pol_i)));
endmodule

bind pof_out_fmt pof_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_eff    (mode_eff),
    .dv_latch_i  (dv_latch_i),
    .dv_pol_i    (dv_pol_i),
    .cb_i        (cb_i),
    .blank_i     (blank_i),
    .hsync_i     (hsync_i),
    .vsync_i     (vsync_i),
    .field_i     (field_i),
    .vbi_valid_i (vbi_valid_i),
    .pix_o       (pix_o),
    .blank_o     (blank_o),
    .hsync_o     (hsync_o),
    .vsync_o     (vsync_o),
    .dvalid_o    (dvalid_o),
    .field_o     (field_o)
);

// File: tb/pof_out_fmt_test.sv
`timescale 1ns/1ps
module pof_out_fmt_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic        latch = 1'b0, duty = 1'b0, pol = 1'b0;
    logic [7:0]  y = 8'h0, cb = 8'h0, cr = 8'h0, r = 8'h0, g = 8'h0, b = 8'h0;
    logic        blank = 1'b1, hs = 1'b0, vs = 1'b0, fld = 1'b0, vbi = 1'b0;
    logic [15:0] pix;
    logic        blank_o, hsync_o, vsync_o, dvalid_o, vbi_o, field_o;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    pof_out_fmt uut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .dv_latch_i(latch),
        .dv_duty_i(duty), .dv_pol_i(pol), .y_i(y), .cb_i(cb), .cr_i(cr),
        .r_i(r), .g_i(g), .b_i(b), .blank_i(blank), .hsync_i(hs),
        .vsync_i(vs), .field_i(fld), .vbi_valid_i(vbi), .pix_o(pix),
        .blank_o(blank_o), .hsync_o(hsync_o), .vsync_o(vsync_o),
        .dvalid_o(dvalid_o), .vbi_valid_o(vbi_o), .field_o(field_o)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic set_mode(input logic [1:0] m);
        blank = 1'b1; vbi = 1'b0; mode = m;
        tick(); tick();
    endtask

    task automatic t_reset();
        chk("R1 reset pix", pix, 16'h0);
        chk("R1 reset flags", {10'd0, blank_o, hsync_o, vsync_o, dvalid_o, vbi_o, field_o}, 16'h0);
    endtask

    task automatic t_sync();
        blank = 1'b1;
        for (int i = 0; i < 4; i++) begin
            hs = i[0]; vs = i[1]; fld = ~i[0];
            tick();
            chk("R1 sync delay", {13'd0, hsync_o, vsync_o, field_o}, {13'd0, i[0], i[1], ~i[0]});
            chk("R1 blank delay", {15'd0, blank_o}, 16'd1);
        end
        hs = 1'b0; vs = 1'b0; fld = 1'b0;
    endtask

    task automatic t_ycc8();
        logic [7:0] prev;
        logic [7:0] e;
        set_mode(2'd0);
        for (int i = 0; i < 8; i++) begin
            blank = 1'b0; y = 8'h20 + 8'(i); cb = 8'h40 + 8'(i); cr = 8'hC0 + 8'(i);
            tick();
            e = (i % 4 == 0) ? cb : ((i % 4 == 2) ? cr : y);
            chk("R2 byte order", pix, {e, 8'h00});
            chk("R10 strobe active", {15'd0, dvalid_o}, 16'd1);
        end
        blank = 1'b1;
        tick();
        prev = pix[15:8];
        chk("R7 byte blank code", {15'd0, (prev == 8'h10 || prev == 8'h80)}, 16'd1);
        chk("R10 strobe blank", {15'd0, dvalid_o}, 16'd0);
        tick();
        chk("R7 byte blank alternate", {15'd0, (pix[15:8] != prev && (pix[15:8] == 8'h10 || pix[15:8] == 8'h80))}, 16'd1);
        chk("R2 low lane in blank", {8'h00, pix[7:0]}, 16'h0);
        // short line of 3 bytes, then restart
        for (int i = 0; i < 3; i++) begin
            blank = 1'b0; tick();
        end
        blank = 1'b1; tick();
        blank = 1'b0; cb = 8'h5A; y = 8'hA5; cr = 8'h3C;
        tick();
        chk("R3 byte line restarts on Cb", pix, 16'h5A00);
        tick();
        chk("R3 second byte is Y", pix, 16'hA500);
    endtask

    task automatic t_ycc16();
        set_mode(2'd1);
        chk("R7 16-bit blank code", pix, 16'h1080);
        for (int i = 0; i < 6; i++) begin
            blank = 1'b0; y = 8'h30 + 8'(i); cb = 8'h50 + 8'(i); cr = 8'h90 + 8'(i);
            tick();
            chk("R4 16-bit YCbCr", pix, {y, (i % 2 == 0) ? cb : cr});
        end
        for (int i = 0; i < 3; i++) begin
            tick();
        end
        blank = 1'b1; tick();
        chk("R7 16-bit blank code again", pix, 16'h1080);
        blank = 1'b0; y = 8'h77; cb = 8'h11; cr = 8'hEE;
        tick();
        chk("R3 16-bit line restarts on Cb", pix, 16'h7711);
    endtask

    task automatic t_rgb();
        set_mode(2'd2);
        chk("R8 RGB15 blank zero", pix, 16'h0);
        blank = 1'b0; r = 8'hAF; g = 8'h65; b = 8'hD8;
        tick();
        chk("R5 RGB15 pack", pix, 16'h559B);
        set_mode(2'd3);
        chk("R8 RGB16 blank zero", pix, 16'h0);
        blank = 1'b0;
        tick();
        chk("R6 RGB16 pack", pix, 16'hAB3B);
        mode = 2'd2;
        tick(); tick();
        chk("R9 format held mid-line", pix, 16'hAB3B);
        blank = 1'b1; tick(); tick();
        blank = 1'b0;
        tick();
        chk("R9 format taken after blanking", pix, 16'h559B);
    endtask

    task automatic t_vbi();
        set_mode(2'd3);
        r = 8'hAF; g = 8'h65; b = 8'hD8;
        blank = 1'b1; vbi = 1'b1;
        tick();
        chk("R8 VBI data passes", pix, 16'hAB3B);
        chk("R1 VBI flag delay", {14'd0, vbi_o, blank_o}, 16'd3);
        chk("R10 strobe during VBI", {15'd0, dvalid_o}, 16'd1);
        vbi = 1'b0;
        tick();
        chk("R8 forced zero after VBI", pix, 16'h0);
    endtask

    task automatic t_duty();
        set_mode(2'd0);
        duty = 1'b1;
        for (int i = 0; i < 4; i++) begin
            blank = 1'b0; tick();
            chk("R11 duty strobe", {15'd0, dvalid_o}, (i % 2 == 0) ? 16'd1 : 16'd0);
        end
        duty = 1'b0;
        blank = 1'b1; tick();
    endtask

    task automatic t_latch();
        logic prev;
        latch = 1'b1; pol = 1'b1; blank = 1'b1;
        tick();
        prev = dvalid_o;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R12 toggles in blanking", {15'd0, dvalid_o}, {15'd0, ~prev});
            prev = dvalid_o;
        end
        for (int i = 0; i < 4; i++) begin
            blank = 1'b0; tick();
            chk("R12 steady in active", {15'd0, dvalid_o}, 16'd0);
        end
        latch = 1'b0;
        blank = 1'b1; tick();
    endtask

    task automatic t_pol();
        pol = 1'b1;
        blank = 1'b0; tick();
        chk("R13 inverted active", {15'd0, dvalid_o}, 16'd0);
        blank = 1'b1; tick();
        chk("R13 inverted blank", {15'd0, dvalid_o}, 16'd1);
        pol = 1'b0; tick();
        chk("R13 normal blank", {15'd0, dvalid_o}, 16'd0);
    endtask

    initial begin
        #(4 * 200000);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #9;
        t_reset();
        rst_n = 1'b1;
        tick();
        t_sync();
        t_ycc8();
        t_ycc16();
        t_rgb();
        t_vbi();
        t_duty();
        t_latch();
        t_pol();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule